// File: doc/BRIEF.md
# Bit-exact 8x8 inverse DCT engine

This block turns one 8x8 block of dequantized transform coefficients into 64 residual samples for a video decoder. The transform is done in two passes through one shared 1-D butterfly. The first pass works on the rows and the second on the columns of the intermediate result. The arithmetic is normative: every product, sum and truncation point is fixed. Two designs that follow these rules give the same bits for any input, including blocks whose intermediate sums overflow.

Coefficients arrive one per accepted cycle over a valid/ready handshake in raster order. The 64 intermediate values are held in a synchronous RAM, so they map onto on-chip block memory. The same RAM then holds the rounded column results, and these are streamed out in raster order on 64 consecutive cycles. The engine takes the next block only once the last sample of the current block has left.

Top module: `idct8x8_engine`

## Requirements
- R1: A coefficient is taken on each rising clock edge where `in_valid` and `in_ready` are both high. The coefficient is the 14-bit two's-complement value on `in_coef`. The n-th coefficient taken in a block (n = 0..63) is the one at row n/8, column n%8.
- R2: Every cosine product is formed as (K * x) modulo 2^32, read as a signed 32-bit value and shifted right arithmetically by 16. Here x is a signed 32-bit value and K is one of the unsigned constants K1=64277, K2=60547, K3=54491, K4=46341, K5=36410, K6=25080, K7=12785.
- R3: The first pass applies the 1-D transform of R5 to each row. Each of its eight 32-bit results is stored as its 16 least significant bits, read as signed. Overflow wraps around and is never saturated.
- R4: The second pass applies the 1-D transform of R5 to each column of the stored first-pass values. Each output sample is the low 16 bits of ((y + 8) modulo 2^32) shifted right arithmetically by 4.
- R5: The 1-D transform of inputs v0..v7 uses 32-bit wrapping adds and the product M(K,x) of R2, and is defined as follows.
  - a=M(K1,v1)+M(K7,v7); b=M(K7,v1)-M(K1,v7); c=M(K3,v3)+M(K5,v5); d=M(K3,v5)-M(K5,v3).
  - e=M(K4,v0+v4); f=M(K4,v0-v4); g=M(K2,v2)+M(K6,v6); h=M(K6,v2)-M(K2,v6).
  - p=M(K4,a-c); q=M(K4,b-d); s=e+g; t=e-g; u=f+p; w=f-p; z=q-h; r=q+h.
  - The outputs are y0=s+(a+c), y7=s-(a+c), y1=u+r, y2=u-r, y3=t+(b+d), y4=t-(b+d), y5=w+z, y6=w-z.
- R6: The 64 samples of a block appear on `out_data` in raster order (index = row*8+column), with `out_valid` high on 64 consecutive cycles and low otherwise.
- R7: `in_ready` is low from the 64th accepted coefficient of a block until the cycle after the last output sample of that block. `in_ready` and `out_valid` are never high together.
- R8: While and after reset, `out_valid` is low. A few cycles after reset is released, `in_ready` is high.
- R9: A block whose only non-zero coefficient is the top-left one gives 64 equal samples. For the value +100 every sample is 3; for -100 every sample is -3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A coefficient is offered |
| in_ready | output | 1 | The engine takes a coefficient this cycle |
| in_coef | input | 14 | Signed coefficient, raster order |
| out_valid | output | 1 | An output sample is present |
| out_data | output | 16 | Signed residual sample, raster order |

## Verification
An all-zero block and single-term blocks separate the even half from the odd half of the butterfly. They also show whether a coefficient lands in the wrong row or column, or whether the transposed read takes the wrong index. Top-left-only blocks of both signs are checked against hand-computed constants, which pins down the floor behaviour of the arithmetic shifts and the +8 rounding. Random blocks over the full 14-bit range and saturated blocks (all +8191, and a checkerboard of +8191 and -8192) force wraparound in both passes, so any clamping or any change of truncation point shows up. A stream with random gaps in `in_valid`, followed by back-to-back blocks, tests the handshake and the input lock-out.

// File: rtl/idct_pkg.sv
package idct_pkg;

  // transform geometry (fixed by the transform definition)
  localparam int BLK_N    = 8;
  localparam int BLK_AREA = BLK_N * BLK_N;
  localparam int IDX_W    = $clog2(BLK_N);
  localparam int ADR_W    = $clog2(BLK_AREA);

  // unsigned 16-bit cosine multipliers
  localparam logic [15:0] K1 = 16'd64277;
  localparam logic [15:0] K2 = 16'd60547;
  localparam logic [15:0] K3 = 16'd54491;
  localparam logic [15:0] K4 = 16'd46341;
  localparam logic [15:0] K5 = 16'd36410;
  localparam logic [15:0] K6 = 16'd25080;
  localparam logic [15:0] K7 = 16'd12785;

  typedef enum logic [2:0] {
    PH_LOAD,   // collect one row of coefficients
    PH_RWR,    // write the row transform into the RAM
    PH_CRD,    // read one column back from the RAM
    PH_CWR,    // write the rounded column transform back
    PH_OUT     // stream the block out in raster order
  } phase_t;

endpackage

// File: rtl/idct_bfly.sv
module idct_bfly
  import idct_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 32
) (
  input  logic signed [IN_W-1:0]  x [BLK_N],
  output logic signed [ACC_W-1:0] y [BLK_N]
);

  // (K * v) mod 2^ACC_W, then arithmetic shift by the constant width
  function automatic logic signed [ACC_W-1:0] cmul(input logic [15:0] k,
                                                   input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] kw;
    logic signed [ACC_W-1:0] p;
    kw = $signed({{(ACC_W-16){1'b0}}, k});
    p  = kw * v;
    return p >>> 16;
  endfunction

  logic signed [ACC_W-1:0] v [BLK_N];
  logic signed [ACC_W-1:0] od_a, od_b, od_c, od_d, od_p, od_q, od_sum_ac, od_sum_bd;
  logic signed [ACC_W-1:0] ev_e, ev_f, ev_g, ev_h, ev_s, ev_t;
  logic signed [ACC_W-1:0] mx_u, mx_w, mx_z, mx_r;

  generate
    for (genvar gi = 0; gi < BLK_N; gi++) begin : g_ext
      assign v[gi] = {{(ACC_W-IN_W){x[gi][IN_W-1]}}, x[gi]};
    end
  endgenerate

  always_comb begin
    // odd half
    od_a      = cmul(K1, v[1]) + cmul(K7, v[7]);
    od_b      = cmul(K7, v[1]) - cmul(K1, v[7]);
    od_c      = cmul(K3, v[3]) + cmul(K5, v[5]);
    od_d      = cmul(K3, v[5]) - cmul(K5, v[3]);
    od_p      = cmul(K4, od_a - od_c);
    od_q      = cmul(K4, od_b - od_d);
    od_sum_ac = od_a + od_c;
    od_sum_bd = od_b + od_d;
    // even half
    ev_e      = cmul(K4, v[0] + v[4]);
    ev_f      = cmul(K4, v[0] - v[4]);
    ev_g      = cmul(K2, v[2]) + cmul(K6, v[6]);
    ev_h      = cmul(K6, v[2]) - cmul(K2, v[6]);
    ev_s      = ev_e + ev_g;
    ev_t      = ev_e - ev_g;
    // mixing stage
    mx_u      = ev_f + od_p;
    mx_w      = ev_f - od_p;
    mx_z      = od_q - ev_h;
    mx_r      = od_q + ev_h;
    // outputs
    y[0]      = ev_s + od_sum_ac;
    y[7]      = ev_s - od_sum_ac;
    y[1]      = mx_u + mx_r;
    y[2]      = mx_u - mx_r;
    y[3]      = ev_t + od_sum_bd;
    y[4]      = ev_t - od_sum_bd;
    y[5]      = mx_w + mx_z;
    y[6]      = mx_w - mx_z;
  end

endmodule

// File: rtl/idct_tram.sv
module idct_tram #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // write side
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read side
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/idct_seq.sv
module idct_seq
  import idct_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [IDX_W-1:0] sel_idx,
  output logic             col_mode,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx,
  output logic             ram_we,
  output logic [ADR_W-1:0] ram_waddr,
  output logic             ram_re,
  output logic [ADR_W-1:0] ram_raddr,
  output logic             out_valid
);

  localparam logic [IDX_W:0]   STEP_LAST = (IDX_W+1)'(BLK_N - 1);
  localparam logic [IDX_W:0]   STEP_END  = (IDX_W+1)'(BLK_N);
  localparam logic [IDX_W-1:0] LINE_LAST = IDX_W'(BLK_N - 1);
  localparam logic [ADR_W:0]   OCNT_END  = (ADR_W+1)'(BLK_AREA);

  phase_t           ph_q, ph_d;
  logic [IDX_W:0]   step_q, step_d;
  logic [IDX_W-1:0] line_q, line_d;
  logic [ADR_W:0]   ocnt_q, ocnt_d;
  logic             ov_q, ov_d;

  assign sel_idx   = step_q[IDX_W-1:0];
  assign out_valid = ov_q;

  // next-state and output decode
  always_comb begin
    ph_d      = ph_q;
    step_d    = step_q;
    line_d    = line_q;
    ocnt_d    = ocnt_q;
    ov_d      = 1'b0;
    in_ready  = 1'b0;
    col_mode  = 1'b0;
    cap_en    = 1'b0;
    cap_idx   = IDX_W'(step_q - 1'b1);
    ram_we    = 1'b0;
    ram_waddr = {line_q, step_q[IDX_W-1:0]};
    ram_re    = 1'b0;
    ram_raddr = {step_q[IDX_W-1:0], line_q};
    unique case (ph_q)
      PH_LOAD: begin
        in_ready = arst_n;
        if (in_valid && arst_n) begin
          step_d = step_q + 1'b1;
          if (step_q == STEP_LAST) begin
            step_d = '0;
            ph_d   = PH_RWR;
          end
        end
      end
      PH_RWR: begin
        ram_we = 1'b1;
        step_d = step_q + 1'b1;
        if (step_q == STEP_LAST) begin
          step_d = '0;
          if (line_q == LINE_LAST) begin
            line_d = '0;
            ph_d   = PH_CRD;
          end else begin
            line_d = line_q + 1'b1;
            ph_d   = PH_LOAD;
          end
        end
      end
      PH_CRD: begin
        ram_re = (step_q != STEP_END);
        cap_en = (step_q != '0);
        step_d = step_q + 1'b1;
        if (step_q == STEP_END) begin
          step_d = '0;
          ph_d   = PH_CWR;
        end
      end
      PH_CWR: begin
        ram_we    = 1'b1;
        col_mode  = 1'b1;
        ram_waddr = {step_q[IDX_W-1:0], line_q};
        step_d    = step_q + 1'b1;
        if (step_q == STEP_LAST) begin
          step_d = '0;
          if (line_q == LINE_LAST) begin
            line_d = '0;
            ocnt_d = '0;
            ph_d   = PH_OUT;
          end else begin
            line_d = line_q + 1'b1;
            ph_d   = PH_CRD;
          end
        end
      end
      PH_OUT: begin
        ram_raddr = ocnt_q[ADR_W-1:0];
        if (ocnt_q != OCNT_END) begin
          ram_re = 1'b1;
          ov_d   = 1'b1;
          ocnt_d = ocnt_q + 1'b1;
        end else begin
          ocnt_d = '0;
          ph_d   = PH_LOAD;
        end
      end
      default: ph_d = PH_LOAD;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_q   <= PH_LOAD;
      step_q <= '0;
      line_q <= '0;
      ocnt_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      step_q <= step_d;
      line_q <= line_d;
      ocnt_q <= ocnt_d;
      ov_q   <= ov_d;
    end
  end

endmodule

// File: rtl/idct8x8_engine.sv
module idct8x8_engine
  import idct_pkg::*;
#(
  parameter int COEF_W = 14,
  parameter int SMP_W  = 16,
  parameter int ACC_W  = 32,
  parameter int RND_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COEF_W-1:0] in_coef,
  output logic              out_valid,
  output logic [SMP_W-1:0]  out_data
);

  localparam logic signed [ACC_W-1:0] RND_BIAS = ACC_W'(1 << (RND_SH - 1));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // sequencer
  logic             col_mode, cap_en, ram_we, ram_re;
  logic [IDX_W-1:0] sel_idx, cap_idx;
  logic [ADR_W-1:0] ram_waddr, ram_raddr;
  logic [SMP_W-1:0] ram_wdata, ram_rdata;

  idct_seq i_seq (
    .clk       (clk),
    .arst_n    (srst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sel_idx   (sel_idx),
    .col_mode  (col_mode),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .out_valid (out_valid)
  );

  // one line of butterfly operands, loaded from the input or the RAM
  logic                    row_fire;
  logic signed [SMP_W-1:0] coef_ext;
  logic signed [SMP_W-1:0] xr_q [BLK_N];
  logic signed [ACC_W-1:0] yv   [BLK_N];

  assign row_fire = in_valid && in_ready;
  assign coef_ext = {{(SMP_W-COEF_W){in_coef[COEF_W-1]}}, in_coef};

  generate
    for (genvar gi = 0; gi < BLK_N; gi++) begin : g_line
      logic                    ld_en;
      logic signed [SMP_W-1:0] ld_val;

      always_comb begin
        ld_en  = (row_fire && (sel_idx == IDX_W'(gi))) ||
                 (cap_en   && (cap_idx == IDX_W'(gi)));
        ld_val = row_fire ? coef_ext : $signed(ram_rdata);
      end

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n)    xr_q[gi] <= '0;
        else if (ld_en) xr_q[gi] <= ld_val;
      end
    end
  endgenerate

  idct_bfly #(
    .IN_W  (SMP_W),
    .ACC_W (ACC_W)
  ) i_bfly (
    .x (xr_q),
    .y (yv)
  );

  // write-back: wrap to the sample width, rounding in the column pass
  logic signed [ACC_W-1:0] ysel;

  always_comb begin
    ysel = yv[sel_idx];
    if (col_mode) ram_wdata = SMP_W'((ysel + RND_BIAS) >>> RND_SH);
    else          ram_wdata = SMP_W'(ysel);
  end

  idct_tram #(
    .DW    (SMP_W),
    .DEPTH (BLK_AREA)
  ) i_tram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  assign out_data = ram_rdata;

endmodule

// File: rtl/idct_engine_chk.sv
module idct_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid
);

  logic [6:0] acc_q;   // coefficients taken for the block in flight
  logic [5:0] oc_q;    // samples emitted, modulo 64

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      oc_q  <= '0;
    end else begin
      if (in_valid && in_ready)            acc_q <= acc_q + 1'b1;
      else if (out_valid && oc_q == 6'd63) acc_q <= '0;
      if (out_valid) oc_q <= oc_q + 1'b1;
    end
  end

  // R7: input and output phases never overlap
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R7: a complete block locks the input
  p_locked_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == 7'd64) |-> !in_ready);

  // R6: samples only exist for a fully received block
  p_out_after_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_q == 7'd64));

  // R6: a burst is contiguous
  p_burst_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && oc_q != 6'd63) |=> out_valid);

  // R6: a burst ends on a 64-sample boundary
  p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (oc_q == 6'd0));

  // R8: nothing is emitted before a block was taken
  p_quiet_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == 7'd0) |-> !out_valid);

endmodule

bind idct8x8_engine idct_engine_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid)
);

// File: tb/test_idct8x8_engine.sv
module test_idct8x8_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_coef = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;

  always #5 clk = ~clk;

  idct8x8_engine i_idct8x8_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_coef   (in_coef),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int    checks = 0;
  int    fails  = 0;
  int    exp_q[$];
  string tag_q[$];
  int    pend = 0;
  int    run_len = 0;
  int    gap_pct = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // reference arithmetic (R2, R5), 32-bit int wraps naturally
  function automatic int cm(input int k, input int x);
    int p;
    p = k * x;
    return p >>> 16;
  endfunction

  function automatic void tx(input int v[8], output int o[8]);
    int a, b, c, d, e, f, g, h, p, q, s, t, u, w, z, r;
    a = cm(64277, v[1]) + cm(12785, v[7]);
    b = cm(12785, v[1]) - cm(64277, v[7]);
    c = cm(54491, v[3]) + cm(36410, v[5]);
    d = cm(54491, v[5]) - cm(36410, v[3]);
    e = cm(46341, v[0] + v[4]);
    f = cm(46341, v[0] - v[4]);
    g = cm(60547, v[2]) + cm(25080, v[6]);
    h = cm(25080, v[2]) - cm(60547, v[6]);
    p = cm(46341, a - c);
    q = cm(46341, b - d);
    s = e + g; t = e - g; u = f + p; w = f - p; z = q - h; r = q + h;
    o[0] = s + (a + c); o[7] = s - (a + c);
    o[1] = u + r;       o[2] = u - r;
    o[3] = t + (b + d); o[4] = t - (b + d);
    o[5] = w + z;       o[6] = w - z;
  endfunction

  // R3 row truncation, R4 column rounding
  function automatic void model(input int cf[64], output int res[64]);
    int mid[64];
    int v[8];
    int o[8];
    for (int rw = 0; rw < 8; rw++) begin
      for (int k = 0; k < 8; k++) v[k] = cf[rw*8+k];
      tx(v, o);
      for (int k = 0; k < 8; k++) mid[rw*8+k] = int'(shortint'(o[k]));
    end
    for (int cl = 0; cl < 8; cl++) begin
      for (int k = 0; k < 8; k++) v[k] = mid[k*8+cl];
      tx(v, o);
      for (int k = 0; k < 8; k++) res[k*8+cl] = int'(shortint'((o[k] + 8) >>> 4));
    end
  endfunction

  // R1: drive one block in raster order, optionally with gaps
  task automatic send_block(input int cf[64], input string tag, input bit use_model, input int konst);
    int res[64];
    if (use_model) model(cf, res);
    else for (int i = 0; i < 64; i++) res[i] = konst;
    for (int i = 0; i < 64; i++) begin
      exp_q.push_back(res[i]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 64; i++) begin
      forever begin
        @(negedge clk);
        if (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
          in_valid = 1'b0;
          continue;
        end
        in_valid = 1'b1;
        in_coef  = cf[i][13:0];
        if (in_ready) break;
      end
      if (i == 63) pend++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: sampled 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (pend > 0) check(!in_ready, "R7 ready low while block in flight", int'(in_ready), 0);
        if (out_valid) begin
          if (exp_q.size() == 0) check(1'b0, "R6 unexpected sample", int'($signed(out_data)), 0);
          else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
          end
          run_len++;
          if (run_len == 64) pend--;
        end else if (run_len != 0) begin
          check(run_len == 64, "R6 burst length", run_len, 64);
          check(in_ready == 1'b1, "R7 ready after burst", int'(in_ready), 1);
          run_len = 0;
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cf[64];
    // R8 during and after reset
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);

    // R3 zero block
    for (int i = 0; i < 64; i++) cf[i] = 0;
    send_block(cf, "R3 zero block", 1'b1, 0);

    // R9 / R4 top-left only, hand-computed constants
    cf[0] = 100;
    send_block(cf, "R9 top-left +100", 1'b0, 3);
    cf[0] = -100;
    send_block(cf, "R9 top-left -100", 1'b0, -3);

    // R5 single odd and single even terms in different rows and columns
    cf[0] = 0; cf[1] = 1000;
    send_block(cf, "R5 single term (0,1)", 1'b1, 0);
    cf[1] = 0; cf[9*2+2] = -777;
    send_block(cf, "R5 single term (2,4)", 1'b1, 0);
    cf[20] = 0; cf[63] = 4095;
    send_block(cf, "R5 single term (7,7)", 1'b1, 0);

    // R2 / R4 random moderate blocks with input gaps (R1)
    gap_pct = 40;
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 64; i++) cf[i] = int'($urandom % 1024) - 512;
      send_block(cf, "R1 gapped random block", 1'b1, 0);
    end
    gap_pct = 0;

    // R2 full-range random blocks, back to back
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 64; i++) cf[i] = int'($urandom % 16384) - 8192;
      send_block(cf, "R2 full-range random", 1'b1, 0);
    end

    // R3 saturated blocks force 16-bit wraparound
    for (int i = 0; i < 64; i++) cf[i] = 8191;
    send_block(cf, "R3 all +8191 wrap", 1'b1, 0);
    for (int i = 0; i < 64; i++) cf[i] = (((i >> 3) + i) % 2 == 0) ? 8191 : -8192;
    send_block(cf, "R3 checkerboard wrap", 1'b1, 0);

    // drain
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(pend == 0, "R6 all blocks emitted", pend, 0);
    check(in_ready == 1'b1, "R7 ready when idle", int'(in_ready), 1);
    finish_run();
  end

endmodule